// File: doc/BRIEF.md
# Double-Precision Floating-Point Comparator

This block compares two IEEE-754 binary64 operands and reports their relation as a one-hot four-bit condition code: less, greater, equal or unordered. It follows the IEEE comparison rules rather than a plain integer compare. Any NaN makes the result unordered. Zeros are equal whatever their sign. A negative operand reads as the lesser one when the signs differ.

Two forms are offered, selected per request. The quiet form flags only signalling NaNs. The signalling form also raises an invalid-compare flag. It does so when a NaN meets the invalid-operation enable input, or when either operand is a quiet NaN. A request is presented with a valid strobe, and its result appears on registered outputs together with a done strobe one clock later.

Top module: `fp64_cmp`

## Requirements
- R1: `done` is high exactly in the cycle after a cycle with `valid` high, and low otherwise. All outputs are zero after reset.
- R2: If either operand is a NaN (exponent bits 62:52 all ones and fraction bits 51:0 nonzero), `cc` = 4'b1000 (unordered). Otherwise it is never unordered. The encoding is bit0 less, bit1 greater, bit2 equal, bit3 unordered.
- R3: `snan_flag` is set when either operand is a signalling NaN (NaN with fraction bit 51 clear). This holds in both forms.
- R4: In the signalling form (`ordered` = 1) with a NaN operand, `inv_flag` is set if `inv_en` is high or either operand is a quiet NaN (fraction bit 51 set). In the quiet form, or with no NaN operand, `inv_flag` is 0.
- R5: Two zeros (any signs) compare equal.
- R6: With differing signs and not both zero, the operand whose bit 63 is set is the lesser, so -0 against a positive nonzero value gives less.
- R7: With equal signs and non-NaN operands, magnitude orders infinity above finite nonzero values (subnormals included) above zero. Positive operands map the larger magnitude of `a` to greater. Negative operands reverse the sense.
- R8: Two infinities of the same sign compare equal. Two finite operands of the same sign compare equal only when their bit patterns are identical.
- R9: Whenever `done` is high, `cc` is one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Request strobe |
| ordered | input | 1 | 1 = signalling form, 0 = quiet form |
| inv_en | input | 1 | Invalid-operation enable |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| done | output | 1 | Result valid strobe |
| cc | output | 4 | Condition code {unord, eq, gt, lt} |
| snan_flag | output | 1 | Signalling-NaN invalid flag |
| inv_flag | output | 1 | Invalid-compare flag |

## Verification
Every cycle, the assertions check that `done` trails `valid` by one clock and that `cc` is one-hot when `done` is high. They also check that the unordered code and the two flags agree with the registered NaN status of the operands. The ordering rules need chosen operand pairs to show: signed zeros, mixed signs, sign reversal for negatives, infinities, subnormals, and the effect of `inv_en`. The bench's scenarios exercise these against a reference function.

// File: rtl/fp64_cmp.sv
module fp64_cmp #(
  parameter int W  = 64,
  parameter int EW = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic         ordered,
  input  logic         inv_en,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         done,
  output logic [3:0]   cc,
  output logic         snan_flag,
  output logic         inv_flag
);
  localparam int FW = W - 1 - EW;

  logic a_exp1, b_exp1, a_frac0, b_frac0;
  logic a_nan, b_nan, a_qn, b_qn, a_sn, b_sn, any_nan;
  logic a_zero, b_zero, a_sg, b_sg;
  logic mag_lt, mag_gt;
  logic [3:0] cc_n;

  assign a_exp1  = &op_a[W-2:FW];
  assign b_exp1  = &op_b[W-2:FW];
  assign a_frac0 = ~|op_a[FW-1:0];
  assign b_frac0 = ~|op_b[FW-1:0];
  assign a_nan   = a_exp1 & ~a_frac0;
  assign b_nan   = b_exp1 & ~b_frac0;
  assign a_qn    = a_nan & op_a[FW-1];
  assign b_qn    = b_nan & op_b[FW-1];
  assign a_sn    = a_nan & ~op_a[FW-1];
  assign b_sn    = b_nan & ~op_b[FW-1];
  assign any_nan = a_nan | b_nan;
  assign a_zero  = ~|op_a[W-2:0];
  assign b_zero  = ~|op_b[W-2:0];
  assign a_sg    = op_a[W-1];
  assign b_sg    = op_b[W-1];
  assign mag_lt  = op_a[W-2:0] < op_b[W-2:0];
  assign mag_gt  = op_a[W-2:0] > op_b[W-2:0];

  always_comb begin
    if (any_nan)                 cc_n = 4'b1000;
    else if (a_zero && b_zero)   cc_n = 4'b0100;
    else if (a_sg != b_sg)       cc_n = a_sg ? 4'b0001 : 4'b0010;
    else if (mag_lt)             cc_n = a_sg ? 4'b0010 : 4'b0001;
    else if (mag_gt)             cc_n = a_sg ? 4'b0001 : 4'b0010;
    else                         cc_n = 4'b0100;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      cc <= '0;
      snan_flag <= 1'b0;
      inv_flag <= 1'b0;
    end else begin
      done <= valid;
      if (valid) begin
        cc <= cc_n;
        snan_flag <= a_sn | b_sn;
        inv_flag <= ordered & any_nan & (inv_en | a_qn | b_qn);
      end
    end
  end
endmodule

module fp64_cmp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid,
  input logic        ordered,
  input logic        inv_en,
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic        done,
  input logic [3:0]  cc,
  input logic        snan_flag,
  input logic        inv_flag
);
  logic started;
  always_ff @(posedge clk) started <= rst_n;

  function automatic logic is_nan(input logic [63:0] x);
    return (&x[62:52]) && (|x[51:0]);
  endfunction

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n || !started)
    done == $past(valid)); // R1
  AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(cc) == 1); // R9
  AST_UNORD_NAN: assert property (@(posedge clk) disable iff (!rst_n || !started)
    done |-> (cc[3] == (is_nan($past(op_a)) || is_nan($past(op_b))))); // R2
  AST_SNAN_NEEDS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && snan_flag) |-> cc[3]); // R3
  AST_INV_ORDERED: assert property (@(posedge clk) disable iff (!rst_n || !started)
    (done && inv_flag) |-> (cc[3] && $past(ordered))); // R4
endmodule

bind fp64_cmp fp64_cmp_chk u_chk (.*);

// File: tb/tb_fp64_cmp.sv
module tb_fp64_cmp;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, valid = 0, ordered = 0, inv_en = 0;
  logic [63:0] op_a = '0, op_b = '0;
  logic done, snan_flag, inv_flag;
  logic [3:0] cc;
  int checks = 0, errors = 0;
  bit finished = 0;

  fp64_cmp dut (.*);
  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000, NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QN = 64'h7FF8_0000_0000_0001, SN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] ONE = 64'h3FF0_0000_0000_0000, TWO = 64'h4000_0000_0000_0000;
  localparam logic [63:0] SUB = 64'h0000_0000_0000_0001;

  function automatic bit nan(input logic [63:0] x); return x[62:52] == 11'h7FF && x[51:0] != 0; endfunction
  function automatic bit zro(input logic [63:0] x); return x[62:0] == 0; endfunction
  function automatic int cls(input logic [63:0] x);
    if (zro(x)) return 0;
    if (x[62:52] == 11'h7FF) return 2;
    return 1;
  endfunction

  function automatic logic [3:0] ref_cc(input logic [63:0] a, input logic [63:0] b);
    logic lt;
    if (nan(a) || nan(b)) return 4'b1000;
    if (zro(a) && zro(b)) return 4'b0100;
    if (a[63] != b[63]) return a[63] ? 4'b0001 : 4'b0010;
    if (cls(a) != cls(b)) lt = cls(a) < cls(b);
    else if (a == b) return 4'b0100;
    else if (cls(a) == 2) return 4'b0100;
    else if (a[62:52] != b[62:52]) lt = a[62:52] < b[62:52];
    else lt = a[51:0] < b[51:0];
    if (a[63]) lt = !lt;
    return lt ? 4'b0001 : 4'b0010;
  endfunction

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [63:0] a, input logic [63:0] b,
                     input logic ord, input logic en);
    logic sn, qn, iv;
    @(negedge clk);
    op_a = a; op_b = b; ordered = ord; inv_en = en; valid = 1;
    @(negedge clk);
    valid = 0;
    sn = (nan(a) && !a[51]) || (nan(b) && !b[51]);
    qn = (nan(a) && a[51]) || (nan(b) && b[51]);
    iv = ord && (nan(a) || nan(b)) && (en || qn);
    chk(req, {done, cc, snan_flag}, {1'b1, ref_cc(a, b), sn});
    chk(req, {5'b0, inv_flag}, {5'b0, iv});
    @(negedge clk);
    chk("R1", {5'b0, done}, 6'b0);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {done, cc, snan_flag}, 6'b0);
    chk("R1", {5'b0, inv_flag}, 6'b0);
    rst_n = 1;
    run("R5", PZ, NZ, 0, 0);
    run("R5", NZ, PZ, 1, 1);
    run("R6", NZ, SUB, 0, 0);
    run("R6", ONE, NZ, 0, 0);
    run("R6", NINF, PZ, 0, 0);
    run("R7", ONE, TWO, 0, 0);
    run("R7", ONE | NZ, TWO | NZ, 0, 0);
    run("R7", PINF, TWO, 0, 0);
    run("R7", NINF, TWO | NZ, 0, 0);
    run("R7", SUB, PZ, 0, 0);
    run("R7", SUB | NZ, NZ, 0, 0);
    run("R8", PINF, PINF, 0, 0);
    run("R8", NINF, NINF, 1, 0);
    run("R8", TWO, TWO, 0, 0);
    run("R2", QN, ONE, 0, 0);
    run("R3", SN, ONE, 0, 0);
    run("R3", ONE, SN, 1, 0);
    run("R4", QN, ONE, 1, 0);
    run("R4", ONE, SN, 1, 1);
    run("R4", QN, SN, 0, 1);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      int s;
      s = $urandom(i == 0 ? 32'd1234 : 32'd0) % 4;
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      if (s == 1) b = {~a[63], a[62:0]};
      if (s == 2) b = {a[63], a[62:52], $urandom_range(0, 3) == 0 ? a[51:0] : {$urandom, $urandom} & 52'hF};
      if (s == 3) begin a[62:52] = 11'h7FF; b[62:52] = $urandom_range(0,1) ? 11'h7FF : 11'h0; end
      run("R2 R7 R9", a, b, 1'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule